// File: doc/BRIEF.md
# Absolute Address Physical Mapper

This block converts an absolute address into a physical address for accesses made while virtual translation is switched off. It takes a 64-bit absolute address with two mode flags. The wide flag selects the 64-bit addressing view. The legacy flag selects the older architecture's plain 32-bit view. The block returns a 64-bit physical address whose significant part is `PHYS_W` bits wide, with every higher bit copied from the extension rule. Alongside the address it returns an access-rights triple, because untranslated accesses are never restricted.

In the 32-bit narrow view, the top nibbles of the low word choose one of three windows. The memory window is zero-extended. The I/O window is sign-extended. The firmware window keeps its 32-bit offset and is moved to the top of the physical space.

The mapping logic is purely combinational. A parameter adds an optional output register, with a valid flag travelling beside the data, so that results are timed against a clock.

Top module: `abs_phys_mapper`

## Requirements
- R1: With `in_wide`=1, `out_phys[PHYS_W-1:0]` equals `in_addr[PHYS_W-1:0]`, and every bit from `PHYS_W` to 63 equals `in_addr[PHYS_W-1]`.
- R2: With `in_wide`=0 and `in_legacy`=0, if `in_addr[31:28]` is not 4'hF, then `out_phys` is `{32'h0, in_addr[31:0]}` (memory window).
- R3: With `in_wide`=0 and `in_legacy`=0, if `in_addr[31:28]`=4'hF and `in_addr[27:24]` is nonzero, then `out_phys` is `in_addr[31:0]` sign-extended to 64 bits (I/O window).
- R4: With `in_wide`=0 and `in_legacy`=0, if `in_addr[31:24]`=8'hF0, then `out_phys` is `{32'h0, in_addr[31:0]}` with every bit from `PHYS_W-4` to 63 forced to 1 (firmware window).
- R5: With `in_wide`=0 and `in_legacy`=1, `out_phys` is `{32'h0, in_addr[31:0]}` for every window.
- R6: `in_wide`=1 takes precedence over `in_legacy`: with both set, the R1 result is produced.
- R7: Every result presented with `out_valid`=1 carries `out_rights`=3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R8: With `REG_OUT`=1, a request accepted with `in_valid`=1 at a rising edge appears with `out_valid`=1 after that edge, and a synchronous active-low reset clears `out_valid`, `out_phys` and `out_rights` to zero.
- R9: With `REG_OUT`=1, a cycle with `in_valid`=0 gives `out_valid`=0 after the next edge, and `out_phys` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_addr | input | 64 | Absolute address to map |
| in_wide | input | 1 | 1: 64-bit wide addressing view |
| in_legacy | input | 1 | 1: older architecture, plain 32-bit view in narrow mode |
| out_valid | output | 1 | Result present |
| out_phys | output | 64 | Physical address, extended to 64 bits |
| out_rights | output | 3 | Access rights {execute, write, read} |

## Verification
The bench builds the mapper with `PHYS_W`=40 and `REG_OUT`=1. With a 40-bit space, the wide-mode sign bit sits at bit 39 and the firmware fill starts at bit 36. Both positions lie well inside the 64-bit result, so a wrong boundary index changes a visible bit. The registered variant exposes the one-cycle latency, the hold-on-idle behaviour and the reset state. The directed vectors sit on the window edges (0xEFFFFFFF, 0xF0FFFFFF, 0xF1000000, 0xFFFFFFFF) and are followed by a pseudo-random mix of modes.

// File: rtl/amap_pkg.sv
// Shared types for the absolute address mapper.
// Assumes a 64-bit absolute address and a narrow view of 32 bits.
package amap_pkg;

    localparam int ADDR_W   = 64;
    localparam int NARROW_W = 32;

    // Window of the narrow space chosen by the top two nibbles
    typedef enum logic [1:0] {
        SPACE_MEM = 2'd0,
        SPACE_IO  = 2'd1,
        SPACE_FW  = 2'd2
    } space_e;

    // Extension rule picked from the mode flags
    typedef enum logic [1:0] {
        MODE_WIDE   = 2'd0,
        MODE_NARROW = 2'd1,
        MODE_LEGACY = 2'd2
    } mode_e;

    typedef struct packed {
        logic exec;
        logic wr;
        logic rd;
    } rights_t;

    localparam rights_t RIGHTS_ALL = '{exec: 1'b1, wr: 1'b1, rd: 1'b1};

endpackage

// File: rtl/amap_mode_select.sv
// Picks the extension rule from the two mode flags.
// Assumes the wide flag wins over the legacy flag.
module amap_mode_select
    import amap_pkg::*;
(
    input  logic  wide,
    input  logic  legacy,
    output mode_e mode
);

    // Priority: wide, then legacy, then the narrow window rules
    always_comb begin
        if (wide) begin
            mode = MODE_WIDE;
        end else if (legacy) begin
            mode = MODE_LEGACY;
        end else begin
            mode = MODE_NARROW;
        end
    end

endmodule

// File: rtl/amap_space_decode.sv
// Classifies the low word of an address into memory, I/O or firmware window.
// Assumes the top nibble selects the I/O area, and the next nibble at zero
// marks the firmware window inside it.
module amap_space_decode
    import amap_pkg::*;
(
    input  logic [NARROW_W-1:0] low_word,
    output space_e              space
);

    localparam int TOP_HI = NARROW_W - 1;
    localparam int TOP_LO = NARROW_W - 4;
    localparam int SUB_HI = NARROW_W - 5;
    localparam int SUB_LO = NARROW_W - 8;

    logic top_all_ones;
    logic sub_zero;

    // Evaluate the two nibble conditions
    always_comb begin
        top_all_ones = &low_word[TOP_HI:TOP_LO];
        sub_zero     = ~|low_word[SUB_HI:SUB_LO];
    end

    // Turn the nibble conditions into a window code
    always_comb begin
        if (!top_all_ones) begin
            space = SPACE_MEM;
        end else if (sub_zero) begin
            space = SPACE_FW;
        end else begin
            space = SPACE_IO;
        end
    end

endmodule

// File: rtl/amap_extend.sv
// Builds the 64-bit physical address from the absolute address, the mode
// and the narrow window. Assumes PHYS_W lies between 36 and 54.
module amap_extend
    import amap_pkg::*;
#(
    parameter int PHYS_W = 54
) (
    input  logic [ADDR_W-1:0] addr,
    input  mode_e             mode,
    input  space_e            space,
    output logic [ADDR_W-1:0] phys
);

    localparam int FW_BIT = PHYS_W - 4;
    localparam logic [ADDR_W-1:0] FW_MASK = {ADDR_W{1'b1}} << FW_BIT;

    logic [ADDR_W-1:0] wide_ext;
    logic [ADDR_W-1:0] zero_ext;
    logic [ADDR_W-1:0] sign_ext;
    logic [ADDR_W-1:0] fw_ext;

    // Wide view: keep PHYS_W bits and copy the top kept bit upward
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            wide_ext[i] = (i < PHYS_W) ? addr[i] : addr[PHYS_W-1];
        end
    end

    // Narrow forms: zero, sign and firmware relocation of the low word
    always_comb begin
        zero_ext = {{(ADDR_W-NARROW_W){1'b0}}, addr[NARROW_W-1:0]};
        sign_ext = {{(ADDR_W-NARROW_W){addr[NARROW_W-1]}}, addr[NARROW_W-1:0]};
        fw_ext   = zero_ext | FW_MASK;
    end

    // Pick the form by mode, then by window
    always_comb begin
        unique case (mode)
            MODE_WIDE:   phys = wide_ext;
            MODE_LEGACY: phys = zero_ext;
            default: begin
                unique case (space)
                    SPACE_IO: phys = sign_ext;
                    SPACE_FW: phys = fw_ext;
                    default:  phys = zero_ext;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/amap_out_stage.sv
// Optional output register with a valid flag beside the data.
// REG_OUT=1: one cycle latency, data held while idle, synchronous active-low
// reset. REG_OUT=0: straight pass-through.
module amap_out_stage #(
    parameter int DATA_W  = 67,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    generate
        if (REG_OUT) begin : g_reg
            // Valid flag follows the request by one cycle
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                end
            end

            // Data captured only with a request, held otherwise
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_data <= '0;
                end else if (in_valid) begin
                    out_data <= in_data;
                end
            end

            a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid)
                else $error("a_r8_valid_follows");

            a_r8_data_captured: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (out_data == $past(in_data)))
                else $error("a_r8_data_captured");

            a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(out_data)))
                else $error("a_r9_idle_holds");
        end else begin : g_comb
            // Pass-through variant
            always_comb begin
                out_valid = in_valid;
                out_data  = in_data;
            end
        end
    endgenerate

endmodule

// File: rtl/abs_phys_mapper.sv
// Maps an absolute address to a physical address while translation is off.
// Assumes PHYS_W is between 36 and 54. Grants full rights to every result.
module abs_phys_mapper
    import amap_pkg::*;
#(
    parameter int PHYS_W  = 54,
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] in_addr,
    input  logic        in_wide,
    input  logic        in_legacy,
    output logic        out_valid,
    output logic [63:0] out_phys,
    output logic [2:0]  out_rights
);

    localparam int RIGHTS_W = $bits(rights_t);
    localparam int DATA_W   = ADDR_W + RIGHTS_W;
    localparam int FW_BIT   = PHYS_W - 4;

    generate
        if (PHYS_W > 54 || PHYS_W < 36) begin : g_bad_width
            $error("abs_phys_mapper: PHYS_W must lie between 36 and 54");
        end
    endgenerate

    mode_e             mode;
    space_e            space;
    logic [ADDR_W-1:0] comb_phys;
    rights_t           comb_rights;
    logic [DATA_W-1:0] stage_in;
    logic [DATA_W-1:0] stage_out;

    amap_mode_select u_mode (
        .wide   (in_wide),
        .legacy (in_legacy),
        .mode   (mode)
    );

    amap_space_decode u_space (
        .low_word (in_addr[NARROW_W-1:0]),
        .space    (space)
    );

    amap_extend #(
        .PHYS_W (PHYS_W)
    ) u_ext (
        .addr  (in_addr),
        .mode  (mode),
        .space (space),
        .phys  (comb_phys)
    );

    // Untranslated accesses always carry full rights
    always_comb begin
        comb_rights = RIGHTS_ALL;
        stage_in    = {comb_rights, comb_phys};
    end

    amap_out_stage #(
        .DATA_W  (DATA_W),
        .REG_OUT (REG_OUT)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (stage_in),
        .out_valid (out_valid),
        .out_data  (stage_out)
    );

    // Split the stage payload onto the ports
    always_comb begin
        out_phys   = stage_out[ADDR_W-1:0];
        out_rights = stage_out[DATA_W-1:ADDR_W];
    end

    a_r1_wide_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_wide) |->
            ((comb_phys[PHYS_W-1:0] == in_addr[PHYS_W-1:0]) &&
             ((&comb_phys[63:PHYS_W-1]) || !(|comb_phys[63:PHYS_W-1]))))
        else $error("a_r1_wide_sign");

    a_r2_mem_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && !in_legacy && (in_addr[31:28] != 4'hF)) |->
            (comb_phys == {32'h0, in_addr[31:0]}))
        else $error("a_r2_mem_zero");

    a_r3_io_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && !in_legacy && (in_addr[31:28] == 4'hF) &&
         (in_addr[27:24] != 4'h0)) |->
            (comb_phys == {32'hFFFF_FFFF, in_addr[31:0]}))
        else $error("a_r3_io_sign");

    a_r4_fw_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && !in_legacy && (in_addr[31:24] == 8'hF0)) |->
            ((&comb_phys[63:FW_BIT]) && (comb_phys[31:0] == in_addr[31:0])))
        else $error("a_r4_fw_top");

    a_r5_legacy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && in_legacy) |->
            (comb_phys == {32'h0, in_addr[31:0]}))
        else $error("a_r5_legacy_zero");

    a_r7_full_rights: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rights == 3'b111))
        else $error("a_r7_full_rights");

endmodule

// File: tb/sim_abs_phys_mapper.sv
`timescale 1ns/1ps
module sim_abs_phys_mapper;

    localparam int PW = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        in_wide = 1'b0;
    logic        in_legacy = 1'b0;
    logic        out_valid;
    logic [63:0] out_phys;
    logic [2:0]  out_rights;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] phys;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] last_phys = '0;

    always #2.5 clk = ~clk;

    abs_phys_mapper #(.PHYS_W(PW), .REG_OUT(1'b1)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_addr    (in_addr),
        .in_wide    (in_wide),
        .in_legacy  (in_legacy),
        .out_valid  (out_valid),
        .out_phys   (out_phys),
        .out_rights (out_rights)
    );

    // Expected mapping, written from the requirement text
    function automatic logic [63:0] model(logic [63:0] a, logic w, logic l);
        logic [63:0] r;
        if (w) begin
            for (int i = 0; i < 64; i++) r[i] = (i < PW) ? a[i] : a[PW-1];
        end else if (l) begin
            r = {32'h0, a[31:0]};
        end else if (a[31:28] != 4'hF) begin
            r = {32'h0, a[31:0]};
        end else if (a[27:24] != 4'h0) begin
            r = {32'hFFFF_FFFF, a[31:0]};
        end else begin
            r = {32'h0, a[31:0]} | ({64{1'b1}} << (PW - 4));
        end
        return r;
    endfunction

    function automatic string tag_of(logic [63:0] a, logic w, logic l);
        if (w && l) return "R6";
        if (w) return "R1";
        if (l) return "R5";
        if (a[31:28] != 4'hF) return "R2";
        if (a[27:24] != 4'h0) return "R3";
        return "R4";
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one request and queue its expected result
    task automatic send(logic [63:0] a, logic w, logic l);
        exp_t e;
        @(negedge clk);
        in_addr   = a;
        in_wide   = w;
        in_legacy = l;
        in_valid  = 1'b1;
        e.phys = model(a, w, l);
        e.tag  = tag_of(a, w, l);
        exp_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_addr  = 64'hA5A5_A5A5_A5A5_A5A5;
        end
    endtask

    // Monitor: compare each produced result with the queue head
    always @(negedge clk) begin
        if (!rst_n) begin
            last_phys = '0;
        end else if (out_valid) begin
            if (exp_q.size() == 0) begin
                check("R8", {63'h0, out_valid}, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, out_phys, e.phys);
                check("R7", {61'h0, out_rights}, 64'h7);
            end
            last_phys = out_phys;
        end else begin
            // R9: idle cycle keeps the previous result
            check("R9", out_phys, last_phys);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] s;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", {63'h0, out_valid}, 64'h0);
        check("R8", out_phys, 64'h0);
        check("R8", {61'h0, out_rights}, 64'h0);
        rst_n = 1'b1;

        // R1 wide mode, sign bit at PW-1 set and clear
        send(64'h0000_0080_0000_1234, 1'b0 | 1'b1, 1'b0);
        send(64'h1234_0070_0000_0001, 1'b1, 1'b0);
        // R6 wide overrides legacy
        send(64'hFFFF_FF80_F000_0000, 1'b1, 1'b1);
        // R2 memory window edges
        send(64'hDEAD_BEEF_7000_0010, 1'b0, 1'b0);
        send(64'h0000_0000_EFFF_FFFF, 1'b0, 1'b0);
        // R3 I/O window edges
        send(64'h0000_0000_F100_0000, 1'b0, 1'b0);
        send(64'h1111_1111_FFFF_FFFF, 1'b0, 1'b0);
        // R4 firmware window edges
        send(64'h0000_0000_F000_0000, 1'b0, 1'b0);
        send(64'hFFFF_FFFF_F0FF_FFFF, 1'b0, 1'b0);
        // R5 legacy in every window
        send(64'h0000_0000_F100_0000, 1'b0, 1'b1);
        send(64'h0000_0000_F000_1000, 1'b0, 1'b1);
        send(64'hFFFF_0000_1234_5678, 1'b0, 1'b1);
        idle(3);

        // Spot values worked out by hand for PW=40
        check("R1", model(64'h0000_0080_0000_1234, 1'b1, 1'b0), 64'hFFFF_FF80_0000_1234);
        check("R4", model(64'h0000_0000_F000_0000, 1'b0, 1'b0), 64'hFFFF_FFF0_F000_0000);

        // Pseudo-random mix of modes and windows
        s = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 60; n++) begin
            logic [63:0] a;
            s = s ^ (s << 13);
            s = s ^ (s >> 7);
            s = s ^ (s << 17);
            a = s;
            if (s[40]) a[31:28] = 4'hF;
            if (s[41] && s[42]) a[27:24] = 4'h0;
            send(a, s[43] & s[44], s[45]);
            if (s[46] && s[47]) idle(1);
        end
        idle(3);

        // R8: reset while a request is offered clears the output
        @(negedge clk);
        rst_n     = 1'b0;
        in_valid  = 1'b1;
        in_addr   = 64'h0000_0000_1234_5678;
        in_wide   = 1'b0;
        in_legacy = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", {63'h0, out_valid}, 64'h0);
        check("R8", out_phys, 64'h0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        send(64'h0000_0000_F2AB_CDEF, 1'b0, 1'b0);
        idle(3);

        // R8: every queued result was produced
        check("R8", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule